// File: doc/BRIEF.md
# System Clock Loss Monitor

This block watches a system clock from a second, free-running reference clock. It raises a reset request when the system clock stops producing rising edges for longer than a fixed window, which is nominally 100 µs. Each rising edge of the system clock toggles a flag in the system domain. That flag is synchronised into the reference domain, and every change of the synchronised flag counts as one observed edge. Each observed edge restarts the window, which is counted in reference-clock cycles.

The request goes to the chip's reset arbiter. Once raised, the request holds until one of two things happens: software disables the monitor, or system-clock edges have come back and the arbiter signals that its reset sequence has finished. The block has no connection to the external reset pin. Its only effect is the request line.

The window length is a parameter. By default it is derived from the reference frequency in kHz and the window length in µs: at 125 MHz this gives 12 500 cycles.

Top module: `mcd_top`

## Requirements
- R1: While `ref_rst_n` is low, and on the first cycle after it is released, `rst_req` is 0.
- R2: With `mon_en` high, `rst_req` stays 0 as long as consecutive rising edges of `sys_clk` are no more than `TIMEOUT_CYC` reference cycles apart.
- R3: With `mon_en` high, when `sys_clk` stops, `rst_req` rises between `TIMEOUT_CYC` and `TIMEOUT_CYC+6` reference cycles after the last rising edge. It is never asserted earlier than `TIMEOUT_CYC-2` cycles after that edge.
- R4: Boundary case. A steady gap of exactly `TIMEOUT_CYC` reference cycles between rising edges raises no request. A steady gap of `TIMEOUT_CYC+2` cycles does raise one.
- R5: Within 5 reference cycles of `mon_en` going low, `rst_req` is 0. It then stays 0 for as long as `mon_en` is low, whatever `sys_clk` does.
- R6: Once asserted, `rst_req` stays 1 after `sys_clk` edges resume, until a one-cycle high pulse on `arb_done` arrives. It is 0 within 4 cycles of that pulse.
- R7: An `arb_done` pulse that arrives while `sys_clk` is still stopped, so that no edge has been seen since the request rose, has no effect: `rst_req` stays 1.
- R8: When `mon_en` rises while `sys_clk` is stopped, a new full window starts. `rst_req` is 0 for at least `TIMEOUT_CYC-4` cycles and is 1 by `TIMEOUT_CYC+8` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Independent reference clock; all timing is counted here |
| ref_rst_n | input | 1 | Active-low asynchronous reset |
| sys_clk | input | 1 | Monitored system clock |
| mon_en | input | 1 | Monitor enable; high to arm; synchronised internally |
| arb_done | input | 1 | One-cycle pulse (reference domain) from the arbiter: its reset is complete |
| rst_req | output | 1 | Reset request to the arbiter, level, active high |

## Verification
Two events can land in the same reference cycle: the re-arming edge and the expiry of the window. This happens when the system clock's period equals the window exactly. The bench derives `sys_clk` from the reference clock, so the gap is a deterministic number of cycles. It then runs one period whose gap equals `TIMEOUT_CYC`, where the edge must win and no request appears. It runs a second period two cycles longer, where expiry must win and a request must appear. The release path pairs a resumed edge with the arbiter's completion pulse in the same way. An `arb_done` pulse sent while the clock is still stopped must leave the request standing.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

    // Reference cycles that cover a window given in microseconds.
    function automatic int unsigned window_cycles(int unsigned ref_khz, int unsigned win_us);
        return (ref_khz * win_us) / 1000;
    endfunction

    localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/mcd_sync.sv
module mcd_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d    = chain_q;
        chain_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mcd_toggle.sv
module mcd_toggle (
    input  logic sys_clk,
    input  logic rst_n,
    output logic flag
);
    typedef struct packed {
        logic flag;
    } tog_t;

    tog_t tog_d, tog_q;

    always_comb begin
        tog_d      = tog_q;
        tog_d.flag = ~tog_q.flag;
    end

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) tog_q <= '0;
        else        tog_q <= tog_d;
    end

    assign flag = tog_q.flag;
endmodule

// File: rtl/mcd_edge_det.sv
module mcd_edge_det #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_async,
    output logic edge_p
);
    logic flag_s;

    typedef struct packed {
        logic prev;
    } ed_t;

    ed_t ed_d, ed_q;

    mcd_sync #(.STAGES(STAGES)) u_flag_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (flag_async),
        .q     (flag_s)
    );

    always_comb begin
        ed_d      = ed_q;
        ed_d.prev = flag_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ed_q <= '0;
        else        ed_q <= ed_d;
    end

    assign edge_p = flag_s ^ ed_q.prev;
endmodule

// File: rtl/mcd_timer.sv
module mcd_timer #(
    parameter int unsigned TIMEOUT_CYC = 12500,
    parameter int unsigned CNT_W       = $clog2(TIMEOUT_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             edge_p,
    input  logic             arb_done,
    output logic             req,
    output logic             resumed,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);
    localparam logic [CNT_W-1:0] TOP  = CNT_W'(TIMEOUT_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             req;
        logic             resumed;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic expire;

    always_comb begin
        tmr_d  = tmr_q;
        expire = (tmr_q.cnt >= LAST) && !edge_p;
        if (!en) begin
            tmr_d = '0;
        end else begin
            if (edge_p)              tmr_d.cnt = '0;
            else if (tmr_q.cnt != TOP) tmr_d.cnt = tmr_q.cnt + 1'b1;

            if (expire) begin
                tmr_d.req     = 1'b1;
                tmr_d.resumed = 1'b0;
            end else begin
                if (edge_p) tmr_d.resumed = 1'b1;
                if (tmr_q.req && arb_done && (tmr_q.resumed || edge_p)) begin
                    tmr_d.req     = 1'b0;
                    tmr_d.resumed = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign req     = tmr_q.req;
    assign resumed = tmr_q.resumed;
    assign cnt     = tmr_q.cnt;
endmodule

// File: rtl/mcd_top.sv
module mcd_top #(
    parameter int unsigned REF_KHZ     = 125000,
    parameter int unsigned WINDOW_US   = 100,
    parameter int unsigned TIMEOUT_CYC = mcd_pkg::window_cycles(REF_KHZ, WINDOW_US),
    parameter int unsigned SYNC_STAGES = mcd_pkg::MIN_SYNC_STAGES
) (
    input  logic ref_clk,
    input  logic ref_rst_n,
    input  logic sys_clk,
    input  logic mon_en,
    input  logic arb_done,
    output logic rst_req
);
    localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);

    logic             sys_flag;
    logic             edge_p;
    logic             en_s;
    logic             resumed;
    logic [CNT_W-1:0] cnt;

    mcd_toggle u_toggle (
        .sys_clk (sys_clk),
        .rst_n   (ref_rst_n),
        .flag    (sys_flag)
    );

    mcd_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
        .clk        (ref_clk),
        .rst_n      (ref_rst_n),
        .flag_async (sys_flag),
        .edge_p     (edge_p)
    );

    mcd_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
        .clk   (ref_clk),
        .rst_n (ref_rst_n),
        .d     (mon_en),
        .q     (en_s)
    );

    mcd_timer #(.TIMEOUT_CYC(TIMEOUT_CYC), .CNT_W(CNT_W)) u_timer (
        .clk      (ref_clk),
        .rst_n    (ref_rst_n),
        .en       (en_s),
        .edge_p   (edge_p),
        .arb_done (arb_done),
        .req      (rst_req),
        .resumed  (resumed),
        .cnt      (cnt)
    );
endmodule

// File: rtl/mcd_checker.sv
module mcd_checker #(
    parameter int unsigned TIMEOUT_CYC = 12500,
    parameter int unsigned CNT_W       = $clog2(TIMEOUT_CYC + 1)
) (
    input logic             ref_clk,
    input logic             ref_rst_n,
    input logic             en,
    input logic             edge_p,
    input logic             arb_done,
    input logic             resumed,
    input logic [CNT_W-1:0] cnt,
    input logic             rst_req
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);
    localparam logic [CNT_W-1:0] TOP  = CNT_W'(TIMEOUT_CYC);

    always @(posedge ref_clk) begin
        if (!ref_rst_n) begin
            p_reset_clear_r1: assert (!rst_req);
        end
    end

    p_edge_rearm_r2: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (en && edge_p) |=> (cnt == '0));

    p_expiry_raises_r3: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (en && (cnt >= LAST) && !edge_p) |=> rst_req);

    p_rise_at_limit_r3: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        $rose(rst_req) |-> (cnt == TOP));

    p_disable_quiet_r5: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        !en |=> (!rst_req && cnt == '0));

    p_sticky_r6: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (rst_req && en && !arb_done) |=> rst_req);

    p_done_ignored_r7: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (rst_req && en && arb_done && !resumed && !edge_p) |=> rst_req);
endmodule

bind mcd_top mcd_checker #(.TIMEOUT_CYC(TIMEOUT_CYC), .CNT_W(CNT_W)) u_chk (
    .ref_clk   (ref_clk),
    .ref_rst_n (ref_rst_n),
    .en        (en_s),
    .edge_p    (edge_p),
    .arb_done  (arb_done),
    .resumed   (resumed),
    .cnt       (cnt),
    .rst_req   (rst_req)
);

// File: tb/mcd_top_test.sv
`timescale 1ns/1ps
module mcd_top_test;
    localparam int LIMIT = 40;
    localparam int VEC_N = 6;
    localparam int HALF_TAB [VEC_N] = '{2, 7, 15, 20, 21, 32};
    localparam bit EXP_TAB  [VEC_N] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

    logic ref_clk = 1'b0;
    logic ref_rst_n = 1'b0;
    logic sys_clk = 1'b0;
    logic mon_en = 1'b0;
    logic arb_done = 1'b0;
    logic rst_req;

    bit sys_run = 1'b0;
    int sys_half = 4;
    int sys_cnt = 0;
    int total = 0;
    int bad = 0;

    mcd_top #(.TIMEOUT_CYC(LIMIT)) uut (
        .ref_clk   (ref_clk),
        .ref_rst_n (ref_rst_n),
        .sys_clk   (sys_clk),
        .mon_en    (mon_en),
        .arb_done  (arb_done),
        .rst_req   (rst_req)
    );

    always #4 ref_clk = ~ref_clk;

    // System clock edges are placed on reference falling edges, so gaps are exact.
    always @(negedge ref_clk) begin
        if (!sys_run) begin
            sys_clk = 1'b0;
            sys_cnt = 0;
        end else begin
            sys_cnt++;
            if (sys_cnt >= sys_half) begin
                sys_clk = ~sys_clk;
                sys_cnt = 0;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge ref_clk);
        #1;
    endtask

    task automatic check(input logic got, input logic exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: rst_req=%b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic pulse_done();
        arb_done = 1'b1;
        tick(1);
        arb_done = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(3);
        check(rst_req, 1'b0, "R1 in reset");
        ref_rst_n = 1'b1;
        tick(1);
        check(rst_req, 1'b0, "R1 after release");

        // Vector walk: steady periods around the window (R2, R3, R4).
        for (int v = 0; v < VEC_N; v++) begin
            mon_en  = 1'b0;
            sys_run = 1'b0;
            tick(6);
            sys_half = HALF_TAB[v];
            mon_en   = 1'b1;
            sys_run  = 1'b1;
            tick(200);
            check(rst_req, EXP_TAB[v],
                  (HALF_TAB[v] == 20) ? "R4 gap equals window" :
                  (HALF_TAB[v] == 21) ? "R4 gap window plus two" :
                  EXP_TAB[v] ? "R3 long gap" : "R2 short gap");
        end

        // R5: disable drops a standing request
        mon_en  = 1'b0;
        sys_run = 1'b0;
        tick(5);
        check(rst_req, 1'b0, "R5 disable clears");

        // R2: running clock, no request
        sys_half = 5;
        mon_en   = 1'b1;
        sys_run  = 1'b1;
        tick(60);
        check(rst_req, 1'b0, "R2 running");

        // R3: stop right after a rising edge
        @(posedge sys_clk);
        #1;
        sys_run = 1'b0;
        repeat (LIMIT - 2) @(negedge ref_clk);
        #1;
        check(rst_req, 1'b0, "R3 not early");
        tick(10);
        check(rst_req, 1'b1, "R3 timeout");

        // R7: completion without resumed edges is ignored
        pulse_done();
        tick(3);
        check(rst_req, 1'b1, "R7 done ignored");

        // R6: edges resume, request holds until completion
        sys_run = 1'b1;
        tick(30);
        check(rst_req, 1'b1, "R6 held after resume");
        pulse_done();
        tick(3);
        check(rst_req, 1'b0, "R6 released");
        tick(100);
        check(rst_req, 1'b0, "R2 after release");

        // R5: disabled and stopped, no request
        sys_run = 1'b0;
        mon_en  = 1'b0;
        tick(2 * LIMIT);
        check(rst_req, 1'b0, "R5 stays quiet");

        // R8: enabling with stopped clock starts a full window
        mon_en = 1'b1;
        tick(LIMIT - 4);
        check(rst_req, 1'b0, "R8 fresh window");
        tick(12);
        check(rst_req, 1'b1, "R8 expiry after enable");

        // R1: reset during a request
        ref_rst_n = 1'b0;
        tick(2);
        check(rst_req, 1'b0, "R1 reset clears");
        ref_rst_n = 1'b1;
        tick(1);
        check(rst_req, 1'b0, "R1 after second release");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule